// File: doc/BRIEF.md
# Latched Fault and Event Status Word

This block collects fault and event indications from a switch-monitoring device into one 7-bit status word. Three of them are level conditions: supply over-voltage, temperature warning and thermal shutdown. Each of these latches a flag when its level changes in either direction, so a fault that goes away is reported as well as one that appears. The other inputs are single-cycle strobes. A switch threshold crossing and the end of the first polling cycle both set the switch-change flag. Parity errors and serial framing errors on the host link each set a flag of their own.

The host reads the word through a plain read strobe. The word is on `stat_word` in the cycle the strobe is high. The clock edge that ends that cycle clears every bit, except for bits that are set again in that same cycle. The parity and framing bits are also driven on two separate flag pins. An interrupt line is high while any flag is set. The interface has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Top module: `fault_stat_reg`

## Requirements
- R1: After reset, `stat_word` is 0 and `irq` is low.
- R2: During a cycle with `rd_stb` high, `stat_word` shows the latched word. The clock edge that ends that cycle clears every bit that is not set again in that cycle.
- R3: Bit 6 (over-voltage), bit 5 (temperature warning) and bit 4 (thermal shutdown) go to 1 on the second clock edge after the matching level input changes, for a change from 0 to 1 and for a change from 1 to 0.
- R4: A one-cycle pulse on `sw_change` sets bit 3 at the next clock edge.
- R5: A one-cycle pulse on `poll_done` sets bit 3 at the next clock edge.
- R6: A one-cycle pulse on `parity_err` sets bit 2, and a one-cycle pulse on `frame_err` sets bit 1, at the next clock edge.
- R7: `parity_flag` always equals bit 2 of `stat_word`, and `frame_flag` always equals bit 1.
- R8: Bit 0 of `stat_word` always reads 0.
- R9: A bit set in the same cycle as a read is 1 after that read's clearing edge.
- R10: `irq` is high exactly when some bit of `stat_word` is 1.
- R11: A bit that is 1 stays 1 until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_ovp | input | 1 | Supply over-voltage level |
| lvl_twarn | input | 1 | Temperature warning level |
| lvl_tshut | input | 1 | Thermal shutdown level |
| sw_change | input | 1 | Strobe: a switch input crossed its threshold |
| poll_done | input | 1 | Strobe: the first polling cycle has finished |
| parity_err | input | 1 | Strobe: the last host word failed its parity check |
| frame_err | input | 1 | Strobe: the last host word had the wrong bit count |
| rd_stb | input | 1 | Strobe: read of this register; clears it |
| stat_word | output | 7 | Latched status word |
| parity_flag | output | 1 | Copy of bit 2 |
| frame_flag | output | 1 | Copy of bit 1 |
| irq | output | 1 | High while any status bit is set |

## Verification
The assertions assume that the level inputs are synchronous to `clk` and hold for at least one clock. They also assume that every strobe, including the read strobe, is high for exactly one cycle per event, so one strobe maps to one set or one clear. The random stimulus changes each input only at the falling clock edge and treats each strobe as a fresh one-cycle draw. It also makes levels toggle much less often than strobes fire, so that rises, falls and reads all happen near each other without any signal becoming metastable or glitching.

// File: rtl/fault_stat_pkg.sv
package fault_stat_pkg;
  localparam int STAT_W    = 7;
  localparam int NUM_LVL   = 3;
  localparam int B_OVP     = 6;
  localparam int B_TWARN   = 5;
  localparam int B_TSHUT   = 4;
  localparam int B_SWCHG   = 3;
  localparam int B_PARITY  = 2;
  localparam int B_FRAME   = 1;
  localparam int L_OVP     = 0;
  localparam int L_TWARN   = 1;
  localparam int L_TSHUT   = 2;
endpackage

// File: rtl/lvl_change_det.sv
module lvl_change_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] changed
);
  logic [N-1:0] smp_q;
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_det
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q[i]  <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        smp_q[i]  <= lvl_in[i];
        prev_q[i] <= smp_q[i];
      end
    end
    assign changed[i] = smp_q[i] ^ prev_q[i];

    AST_CHG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      changed[i] && $stable(lvl_in[i]) |=> !changed[i]); // R3
  end
endmodule

// File: rtl/stat_word_reg.sv
module stat_word_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] word_q
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = clr ? '0 : word_q;
    word_d = word_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((word_q & $past(word_q)) == $past(word_q))); // R11
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr && (set_vec == '0) |=> (word_q == '0)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((word_q & $past(set_vec)) == $past(set_vec))); // R9
endmodule

// File: rtl/fault_stat_reg.sv
module fault_stat_reg
  import fault_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_ovp,
  input  logic              lvl_twarn,
  input  logic              lvl_tshut,
  input  logic              sw_change,
  input  logic              poll_done,
  input  logic              parity_err,
  input  logic              frame_err,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] stat_word,
  output logic              parity_flag,
  output logic              frame_flag,
  output logic              irq
);
  logic [NUM_LVL-1:0] lvl_vec;
  logic [NUM_LVL-1:0] lvl_chg;
  logic [STAT_W-1:0]  set_vec;

  assign lvl_vec[L_OVP]   = lvl_ovp;
  assign lvl_vec[L_TWARN] = lvl_twarn;
  assign lvl_vec[L_TSHUT] = lvl_tshut;

  lvl_change_det #(.N(NUM_LVL)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_in  (lvl_vec),
    .changed (lvl_chg)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_OVP]    = lvl_chg[L_OVP];
    set_vec[B_TWARN]  = lvl_chg[L_TWARN];
    set_vec[B_TSHUT]  = lvl_chg[L_TSHUT];
    set_vec[B_SWCHG]  = sw_change | poll_done;
    set_vec[B_PARITY] = parity_err;
    set_vec[B_FRAME]  = frame_err;
  end

  stat_word_reg #(.W(STAT_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (rd_stb),
    .word_q  (stat_word)
  );

  assign parity_flag = stat_word[B_PARITY];
  assign frame_flag  = stat_word[B_FRAME];
  assign irq         = |stat_word;

  AST_SWCHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_change || poll_done) |=> stat_word[B_SWCHG]); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err |=> parity_flag) and (frame_err |=> frame_flag)); // R6
  AST_OVP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl_ovp) != lvl_ovp |=> ##1 stat_word[B_OVP]); // R3
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[0] == 1'b0); // R8
  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_word != '0)); // R10
  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_flag == stat_word[2]) && (frame_flag == stat_word[1])); // R7
endmodule

// File: tb/fault_stat_reg_bench.sv
module fault_stat_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 1500;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lvl_ovp = 0, lvl_twarn = 0, lvl_tshut = 0;
  logic       sw_change = 0, poll_done = 0, parity_err = 0, frame_err = 0;
  logic       rd_stb = 0;
  logic [6:0] stat_word;
  logic       parity_flag, frame_flag, irq;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_stat_reg u_fault_stat_reg (
    .clk(clk), .rst_n(rst_n),
    .lvl_ovp(lvl_ovp), .lvl_twarn(lvl_twarn), .lvl_tshut(lvl_tshut),
    .sw_change(sw_change), .poll_done(poll_done),
    .parity_err(parity_err), .frame_err(frame_err),
    .rd_stb(rd_stb), .stat_word(stat_word),
    .parity_flag(parity_flag), .frame_flag(frame_flag), .irq(irq)
  );

  // Reference model built from R2..R6 and R9
  logic [2:0] m_s1, m_s2;
  logic [6:0] m_stat;

  function automatic logic [6:0] next_word(logic [6:0] cur, logic rd,
      logic [2:0] chg, logic sw, logic pd, logic pe, logic fe);
    logic [6:0] s;
    s = {chg[0], chg[1], chg[2], sw | pd, pe, fe, 1'b0};
    return (rd ? 7'd0 : cur) | s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_stat <= '0;
    end else begin
      m_s1 <= {lvl_tshut, lvl_twarn, lvl_ovp};
      m_s2 <= m_s1;
      m_stat <= next_word(m_stat, rd_stb, m_s1 ^ m_s2,
                          sw_change, poll_done, parity_err, frame_err);
    end
  end

  task automatic check(string req, logic [6:0] got, logic [6:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 word after reset", stat_word, 7'h00);
    check("R1 irq after reset", {6'd0, irq}, 7'h00);
    rst_n = 1'b1;
    tick();

    // R3 rise: two edges
    lvl_ovp = 1'b1;
    tick();
    check("R3 not yet after one edge", stat_word, 7'h00);
    tick();
    check("R3 over-voltage rise", stat_word, 7'h40);
    check("R10 irq high", {6'd0, irq}, 7'h01);
    // R2 read: value visible during strobe, then cleared
    rd_stb = 1'b1;
    check("R2 word visible during read", stat_word, 7'h40);
    tick();
    rd_stb = 1'b0;
    check("R2 cleared after read", stat_word, 7'h00);
    check("R10 irq low", {6'd0, irq}, 7'h00);
    // R3 fall
    lvl_ovp = 1'b0;
    tick(); tick();
    check("R3 over-voltage fall", stat_word, 7'h40);
    do_read();
    // R3 warning
    lvl_twarn = 1'b1;
    tick(); tick();
    check("R3 warning rise", stat_word, 7'h20);
    do_read();
    // R4
    sw_change = 1'b1; tick(); sw_change = 1'b0;
    check("R4 switch change", stat_word, 7'h08);
    do_read();
    // R5
    poll_done = 1'b1; tick(); poll_done = 1'b0;
    check("R5 poll done", stat_word, 7'h08);
    do_read();
    // R6 / R7
    parity_err = 1'b1; tick(); parity_err = 1'b0;
    check("R6 parity bit", stat_word, 7'h04);
    check("R7 parity flag", {5'd0, parity_flag, frame_flag}, 7'h02);
    // R9: frame error coincides with the read
    rd_stb = 1'b1; frame_err = 1'b1; tick(); rd_stb = 1'b0; frame_err = 1'b0;
    check("R9 set during read kept", stat_word, 7'h02);
    check("R7 frame flag", {5'd0, parity_flag, frame_flag}, 7'h01);
    do_read();
    // R11 hold
    lvl_tshut = 1'b1;
    tick(); tick();
    repeat (5) tick();
    check("R11 held without read", stat_word, 7'h10);
    do_read();
    check("R2 read clears held bit", stat_word, 7'h00);

    // Random phase against reference model
    for (int i = 0; i < N_RANDOM; i++) begin
      if ($urandom_range(15) == 0) lvl_ovp   = ~lvl_ovp;
      if ($urandom_range(15) == 0) lvl_twarn = ~lvl_twarn;
      if ($urandom_range(15) == 0) lvl_tshut = ~lvl_tshut;
      sw_change  = ($urandom_range(7) == 0);
      poll_done  = ($urandom_range(11) == 0);
      parity_err = ($urandom_range(9) == 0);
      frame_err  = ($urandom_range(9) == 0);
      rd_stb     = ($urandom_range(3) == 0);
      tick();
      check("R2/R3/R6/R9/R11 random word", stat_word, m_stat);
      check("R7 random mirrors", {5'd0, parity_flag, frame_flag}, {5'd0, m_stat[2], m_stat[1]});
      check("R8 bit0 zero", {6'd0, stat_word[0]}, 7'h00);
      check("R10 random irq", {6'd0, irq}, {6'd0, |m_stat});
    end
    sw_change = 0; poll_done = 0; parity_err = 0; frame_err = 0; rd_stb = 0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule